// File: doc/BRIEF.md
# Multi-format Serial Audio Receiver

This block turns a stereo PCM serial stream (a bit clock, a word clock that marks the channels and one data line) into pairs of left and right two's-complement samples. It runs entirely in the system clock domain. The three serial lines pass through a chain of synchronizing flops. Edges of the bit clock then act as bit events, rising edges for three of the formats and falling edges for the pulse-framed format. The word clock and data are captured in the same cycle as each bit event.

Four framings are selected by `fmt_i`. In left-justified mode the word clock is high for left, and the MSB sits in the first bit slot after a word-clock change. In I2S the word clock is low for left, and the MSB follows one slot after the change. In right-justified mode each half-frame has 32 slots and the word ends on the last one, so the first captured slot depends on the word length. In DSP mode a high pulse on the word clock announces each word. A state machine with four states runs the capture. HUNT waits for framing. LEAD skips slots before the MSB. TAKE shifts bits in. REST discards extra bits. The named transitions are HUNT->LEAD and HUNT->TAKE on a word-clock change, LEAD->TAKE when the slot index reaches the lead count, and TAKE->REST when the bit limit is reached. A word-clock change (any state)->LEAD/TAKE starts a new half-frame. In DSP mode HUNT->TAKE happens when a pulse ends, and TAKE->HUNT happens once the configured number of bits has been taken.

Every captured word is placed at the top of a 24-bit sample. A one-cycle valid strobe presents each completed left/right pair.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and directly after it is released, `valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: With `fmt_i` = 2'b00 (left-justified), the word clock is high for left and low for right. The bit sampled on the first rising bit-clock edge after a word-clock change is the MSB of that channel's word.
- R3: With `fmt_i` = 2'b01 (I2S), the word clock is low for left and high for right. The first slot after a change is ignored, and the MSB is taken from the second slot.
- R4: With `fmt_i` = 2'b10 (right-justified), each half-frame has 32 slots. The word is taken from slot 32-N through slot 31, counting the slot after the change as slot 0. N comes from `wlen_i`: 2'b00=24, 2'b01=20, 2'b10=18, 2'b11=16.
- R5: With `fmt_i` = 2'b11 (DSP), bits are sampled on falling bit-clock edges. The MSB is the first bit sampled low after the word clock was sampled high, and exactly N bits (per the `wlen_i` coding of R4) form the word. The first word after reset is left, and later words alternate between right and left. Bits after a word and before the next pulse are ignored.
- R6: In left-justified and I2S modes, a word of any length up to 24 bits is accepted. Bits beyond the 24th in a half-frame are dropped, so only the first 24 bits of a longer word are kept.
- R7: A word shorter than 24 bits appears in bits 23 downward of its output, and the unused low bits are zero.
- R8: Left-justified mode also accepts packed frames of 16 bit clocks per half-frame, with a 16-bit word filling the half-frame from one word-clock change to the next.
- R9: `valid_o` is high for exactly one cycle per completed pair. In the three word-clock-level formats, the right word completes at the next word-clock change. In DSP mode it completes on its N-th bit. A right word with no left word captured before it in the same frame produces no strobe.
- R10: `left_o` and `right_o` change only in a cycle in which `valid_o` is high, and hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing select: 00 left-justified, 01 I2S, 10 right-justified, 11 DSP |
| wlen_i | input | 2 | Word length: 00=24, 01=20, 10=18, 11=16 (used in right-justified and DSP modes) |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word clock / channel marker |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The assertions check every cycle that the bit count never passes its limit, that no slot-skipping state is ever entered in left-justified or DSP modes, and that commits only follow bit events. They also check that the strobe lasts one cycle, follows a held left word, and is the only time the outputs move. Bit placement can only be shown by the bench's scenarios. These cover the lead slots of I2S and right-justified framing, truncation of over-long words, zero fill of short ones, packed half-frames, the left-first order of DSP words and the suppression of an orphan right word. In each case the bench compares the sample pairs against words it built itself.

// File: rtl/rx_pkg.sv
package rx_pkg;

    localparam int RX_SAMPLE_W  = 24;
    localparam int RX_HALF_SLOTS = 32;
    localparam int RX_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } frame_fmt_e;

    typedef enum logic [1:0] {
        LEN_24 = 2'b00,
        LEN_20 = 2'b01,
        LEN_18 = 2'b10,
        LEN_16 = 2'b11
    } word_len_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LEAD,
        ST_TAKE,
        ST_REST
    } rx_state_e;

    function automatic int len_bits(input word_len_e l);
        case (l)
            LEN_24:  return 24;
            LEN_20:  return 20;
            LEN_18:  return 18;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic fall_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int LANES = 3;
    localparam int LAST  = STAGES - 1;

    logic [LANES-1:0] pipe_q [STAGES];
    logic             sck_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= '0;
            end
            sck_last_q <= 1'b0;
        end else begin
            pipe_q[0] <= {sck_i, ws_i, sd_i};
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
            sck_last_q <= pipe_q[LAST][2];
        end
    end

    assign rise_o = pipe_q[LAST][2] & ~sck_last_q;
    assign fall_o = ~pipe_q[LAST][2] & sck_last_q;
    assign ws_o   = pipe_q[LAST][1];
    assign sd_o   = pipe_q[LAST][0];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int SAMPLE_W   = RX_SAMPLE_W,
    parameter int HALF_SLOTS = RX_HALF_SLOTS,
    localparam int CNT_W     = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  frame_fmt_e          fmt_i,
    input  word_len_e           wlen_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                ws_i,
    input  logic                sd_i,
    output logic                commit_o,
    output logic                commit_right_o,
    output logic [SAMPLE_W-1:0] word_o,
    output logic [CNT_W-1:0]    cnt_o
);
    localparam int SLOT_W = $clog2(HALF_SLOTS + 1);
    localparam logic [SLOT_W-1:0] SLOT_MAX  = SLOT_W'(HALF_SLOTS);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(SAMPLE_W);

    rx_state_e state_q, state_d;

    logic [SLOT_W-1:0]   slot_q, slot_d, slot_nx, lead;
    logic [CNT_W-1:0]    cnt_q, cnt_d, cnt_b, n_bits, limit, wcnt_d;
    logic [SAMPLE_W-1:0] acc_q, acc_d, acc_b, word_d;
    logic seen_q, seen_d, wsp_q, wsp_d, chan_q, chan_d, tog_q, tog_d;
    logic commit_d, commit_right_d;
    logic is_dsp, ev, left_lvl, take;

    // Mode decode
    assign is_dsp   = (fmt_i == FMT_DSP);
    assign ev       = is_dsp ? fall_i : rise_i;
    assign n_bits   = CNT_W'(len_bits(wlen_i));
    assign left_lvl = (fmt_i != FMT_I2S);
    assign limit    = (fmt_i == FMT_RJ || is_dsp) ? n_bits : FULL_CNT;

    always_comb begin
        unique case (fmt_i)
            FMT_I2S: lead = SLOT_W'(1);
            FMT_RJ:  lead = SLOT_MAX - SLOT_W'(n_bits);
            default: lead = '0;
        endcase
    end

    // Next-state and capture logic
    always_comb begin
        state_d        = state_q;
        slot_d         = slot_q;
        chan_d         = chan_q;
        tog_d          = tog_q;
        seen_d         = seen_q;
        wsp_d          = wsp_q;
        acc_b          = acc_q;
        cnt_b          = cnt_q;
        take           = 1'b0;
        commit_d       = 1'b0;
        commit_right_d = chan_q;
        word_d         = acc_q;
        wcnt_d         = cnt_q;
        slot_nx        = (slot_q == SLOT_MAX) ? slot_q : slot_q + 1'b1;

        if (ev) begin
            seen_d = 1'b1;
            wsp_d  = ws_i;
            if (!is_dsp) begin
                if (seen_q && (ws_i != wsp_q)) begin
                    // word-clock change: close the running word, open the next half
                    commit_d = (state_q != ST_HUNT);
                    chan_d   = (ws_i != left_lvl);
                    slot_d   = '0;
                    acc_b    = '0;
                    cnt_b    = '0;
                    if (lead == '0) begin
                        take    = 1'b1;
                        state_d = ST_TAKE;
                    end else begin
                        state_d = ST_LEAD;
                    end
                end else begin
                    slot_d = slot_nx;
                    unique case (state_q)
                        ST_HUNT: state_d = ST_HUNT;
                        ST_LEAD: begin
                            if (slot_nx == lead) begin
                                take    = 1'b1;
                                state_d = ST_TAKE;
                            end
                        end
                        ST_TAKE: begin
                            if (cnt_q < limit) take = 1'b1;
                            else               state_d = ST_REST;
                        end
                        ST_REST: state_d = ST_REST;
                        default: state_d = ST_HUNT;
                    endcase
                end
            end else begin
                unique case (state_q)
                    ST_TAKE: take = 1'b1;
                    default: begin
                        if (seen_q && wsp_q && !ws_i) begin
                            chan_d  = tog_q;
                            acc_b   = '0;
                            cnt_b   = '0;
                            take    = 1'b1;
                            state_d = ST_TAKE;
                        end
                    end
                endcase
            end
        end

        if (take) begin
            acc_d = {acc_b[SAMPLE_W-2:0], sd_i};
            cnt_d = cnt_b + 1'b1;
        end else begin
            acc_d = acc_b;
            cnt_d = cnt_b;
        end

        if (ev && is_dsp && take && (cnt_d == n_bits)) begin
            commit_d       = 1'b1;
            commit_right_d = chan_d;
            word_d         = acc_d;
            wcnt_d         = cnt_d;
            tog_d          = ~chan_d;
            state_d        = ST_HUNT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q         <= '0;
            cnt_q          <= '0;
            acc_q          <= '0;
            seen_q         <= 1'b0;
            wsp_q          <= 1'b0;
            chan_q         <= 1'b0;
            tog_q          <= 1'b0;
            commit_o       <= 1'b0;
            commit_right_o <= 1'b0;
            word_o         <= '0;
            cnt_o          <= '0;
        end else begin
            slot_q         <= slot_d;
            cnt_q          <= cnt_d;
            acc_q          <= acc_d;
            seen_q         <= seen_d;
            wsp_q          <= wsp_d;
            chan_q         <= chan_d;
            tog_q          <= tog_d;
            commit_o       <= commit_d;
            commit_right_o <= commit_right_d;
            word_o         <= word_d;
            cnt_o          <= wcnt_d;
        end
    end

    // R6 / R4: the shift count never passes the mode's bit limit
    a_r6_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R3: only lead-slot formats ever wait in the LEAD state
    a_r3_lead_needs_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> (fmt_i == FMT_I2S || fmt_i == FMT_RJ));

    // R5: pulse framing uses only HUNT and TAKE
    a_r5_dsp_two_states: assert property (@(posedge clk) disable iff (!rst_n)
        is_dsp |-> (state_q == ST_HUNT || state_q == ST_TAKE));

    // R9: a word is only handed on in the cycle after a bit event
    a_r9_commit_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(ev));

endmodule

// File: rtl/rx_word_pair.sv
module rx_word_pair #(
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic                right_i,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    localparam logic [CNT_W:0] FULL = (CNT_W + 1)'(SAMPLE_W);

    logic [CNT_W:0]      shamt;
    logic [SAMPLE_W-1:0] aligned, hold_q;
    logic                have_left_q;

    // Move the MSB of a short word up to the top bit, zero below
    assign shamt   = FULL - {1'b0, cnt_i};
    assign aligned = word_i << shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            have_left_q <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (commit_i) begin
                if (!right_i) begin
                    hold_q      <= aligned;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= hold_q;
                    right_o     <= aligned;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end

    a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r9_pair_needs_left: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(have_left_q));

    a_r10_move_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((left_o != $past(left_o)) || (right_o != $past(right_o))) |-> valid_o);

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import rx_pkg::*;
#(
    parameter int SAMPLE_W    = RX_SAMPLE_W,
    parameter int HALF_SLOTS  = RX_HALF_SLOTS,
    parameter int SYNC_STAGES = RX_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                sck_i,
    input  logic                ws_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);

    logic                rise, fall, ws_s, sd_s;
    logic                commit, commit_right;
    logic [SAMPLE_W-1:0] word;
    logic [CNT_W-1:0]    cnt;

    rx_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .ws_i   (ws_i),
        .sd_i   (sd_i),
        .rise_o (rise),
        .fall_o (fall),
        .ws_o   (ws_s),
        .sd_o   (sd_s)
    );

    rx_frame_fsm #(
        .SAMPLE_W   (SAMPLE_W),
        .HALF_SLOTS (HALF_SLOTS)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .fmt_i          (frame_fmt_e'(fmt_i)),
        .wlen_i         (word_len_e'(wlen_i)),
        .rise_i         (rise),
        .fall_i         (fall),
        .ws_i           (ws_s),
        .sd_i           (sd_s),
        .commit_o       (commit),
        .commit_right_o (commit_right),
        .word_o         (word),
        .cnt_o          (cnt)
    );

    rx_word_pair #(
        .SAMPLE_W (SAMPLE_W)
    ) i_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .right_i  (commit_right),
        .word_i   (word),
        .cnt_i    (cnt),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

endmodule

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;

    localparam logic [1:0] F_LJ = 2'b00, F_I2S = 2'b01, F_RJ = 2'b10, F_DSP = 2'b11;
    localparam int RING = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [1:0]  wlen = 2'b00;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [23:0] left, right;
    logic        valid;

    int checks = 0;
    int fails = 0;
    int n_exp = 0;
    int base_got = 0;
    int n_got = 0;
    int stretch_errs = 0;
    bit prev_valid = 1'b0;
    bit timed_out = 1'b0;
    logic [23:0] exp_l [RING];
    logic [23:0] exp_r [RING];
    logic [23:0] got_l [RING];
    logic [23:0] got_r [RING];

    always #10 clk = ~clk;

    pcm_serial_rx i_pcm_serial_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_i   (fmt),
        .wlen_i  (wlen),
        .sck_i   (sck),
        .ws_i    (ws),
        .sd_i    (sd),
        .left_o  (left),
        .right_o (right),
        .valid_o (valid)
    );

    // Monitor: collects every strobed pair, flags stretched strobes (R9)
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (prev_valid) stretch_errs++;
            got_l[n_got % RING] = left;
            got_r[n_got % RING] = right;
            n_got++;
        end
        prev_valid = valid;
    end

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] mk(input int nbits);
        logic [31:0] r;
        r = $urandom;
        if (nbits < 32) r = r & ~(32'hFFFF_FFFF >> nbits);
        return r;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %06h expected %06h", req, act, exp);
        end
    endtask

    task automatic std_slot(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic dsp_slot(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b1; ws = w; sd = d;
        repeat (4) @(negedge clk);
        sck = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
        rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0;
        repeat (4) @(negedge clk);
        fmt = f; wlen = wl;
        @(negedge clk);
        rst_n = 1'b1;
        base_got = n_got;
        n_exp = 0;
        stretch_errs = 0;
        repeat (2) @(negedge clk);
        check("R1 reset left", left, 24'h0);
        check("R1 reset right", right, 24'h0);
        check("R1 reset valid", {23'h0, valid}, 24'h0);
    endtask

    // One half-frame at word-clock level lvl carrying the left-aligned word val
    task automatic std_half(input logic [1:0] f, input logic lvl, input logic [31:0] val,
                            input int nbits, input int slots);
        for (int i = 0; i < slots; i++) begin
            logic b;
            int   k;
            b = 1'($urandom);
            if (f == F_LJ) begin
                b = (i < nbits) ? val[31-i] : 1'b0;
            end else if (f == F_I2S) begin
                k = i - 1;
                if (i > 0) b = (k < nbits) ? val[31-k] : 1'b0;
            end else begin
                k = i - (slots - nbits);
                if (k >= 0) b = val[31-k];
            end
            std_slot(lvl, b);
        end
    endtask

    task automatic std_frame(input logic [1:0] f, input int nbits, input int slots,
                             input logic [31:0] lv, input logic [31:0] rv);
        logic lvl;
        lvl = (f == F_I2S) ? 1'b0 : 1'b1;
        exp_l[n_exp] = lv[31:8];
        exp_r[n_exp] = rv[31:8];
        n_exp++;
        std_half(f, lvl, lv, nbits, slots);
        std_half(f, ~lvl, rv, nbits, slots);
    endtask

    task automatic preamble(input logic lvl);
        for (int i = 0; i < 3; i++) std_slot(lvl, 1'($urandom));
    endtask

    task automatic dsp_word(input logic [31:0] val, input int nbits);
        for (int k = 0; k < nbits; k++) dsp_slot(1'b0, val[31-k]);
    endtask

    task automatic dsp_frame(input int nbits);
        logic [31:0] lv, rv;
        lv = mk(nbits);
        rv = mk(nbits);
        exp_l[n_exp] = lv[31:8];
        exp_r[n_exp] = rv[31:8];
        n_exp++;
        for (int p = 0; p < 2; p++) begin
            int pw, gap;
            pw  = 1 + int'($urandom % 2);
            gap = int'($urandom % 3);
            for (int i = 0; i < pw; i++) dsp_slot(1'b1, 1'($urandom));
            dsp_word((p == 0) ? lv : rv, nbits);
            for (int i = 0; i < gap; i++) dsp_slot(1'b0, 1'($urandom));
        end
    endtask

    task automatic compare(input string req);
        int got;
        repeat (16) @(negedge clk);
        got = n_got - base_got;
        checks++;
        if (got != n_exp) begin
            fails++;
            $display("FAIL R9 %s pair count: actual %0d expected %0d", req, got, n_exp);
        end
        for (int i = 0; i < n_exp && i < got; i++) begin
            check(req, got_l[(base_got + i) % RING], exp_l[i]);
            check(req, got_r[(base_got + i) % RING], exp_r[i]);
        end
        checks++;
        if (stretch_errs != 0) begin
            fails++;
            $display("FAIL R9 %s strobe width: actual %0d long strobes expected 0", req, stretch_errs);
        end
        if (n_exp > 0) begin
            check("R10 held left", left, exp_l[n_exp-1]);
            check("R10 held right", right, exp_r[n_exp-1]);
        end
    endtask

    task automatic run_all();
        // R2: left-justified, 24-bit, directed extremes then random
        do_reset(F_LJ, 2'b00);
        preamble(1'b0);
        std_frame(F_LJ, 24, 32, 32'h8000_0000, 32'h7FFF_FF00);
        for (int i = 0; i < 3; i++) std_frame(F_LJ, 24, 32, mk(24), mk(24));
        preamble(1'b1);
        compare("R2 left-justified");

        // R6 R7: over-long and short words under left-justified framing
        do_reset(F_LJ, 2'b11);
        preamble(1'b0);
        std_frame(F_LJ, 32, 32, mk(32), mk(32));
        std_frame(F_LJ, 16, 32, mk(16), mk(16));
        std_frame(F_LJ, 20, 32, mk(20), mk(20));
        std_frame(F_LJ, 11, 32, mk(11), mk(11));
        preamble(1'b1);
        compare("R6 R7 left-justified lengths");

        // R8: packed 16-slot half-frames
        do_reset(F_LJ, 2'b00);
        preamble(1'b0);
        for (int i = 0; i < 4; i++) std_frame(F_LJ, 16, 16, mk(16), mk(16));
        preamble(1'b1);
        compare("R8 packed");

        // R3: I2S with one-slot delay, incl. truncation (R6) and short word (R7)
        do_reset(F_I2S, 2'b00);
        preamble(1'b1);
        for (int i = 0; i < 3; i++) std_frame(F_I2S, 24, 32, mk(24), mk(24));
        std_frame(F_I2S, 31, 32, mk(31), mk(31));
        std_frame(F_I2S, 18, 32, mk(18), mk(18));
        preamble(1'b0);
        compare("R3 R6 I2S");

        // R4: right-justified, every word length
        for (int wl = 0; wl < 4; wl++) begin
            do_reset(F_RJ, 2'(wl));
            preamble(1'b0);
            for (int i = 0; i < 3; i++)
                std_frame(F_RJ, len_of(2'(wl)), 32, mk(len_of(2'(wl))), mk(len_of(2'(wl))));
            preamble(1'b1);
            compare("R4 right-justified");
        end

        // R5: pulse framing, left first after reset, gaps ignored
        for (int s = 0; s < 2; s++) begin
            logic [1:0] wl;
            wl = (s == 0) ? 2'b00 : 2'b11;
            do_reset(F_DSP, wl);
            dsp_slot(1'b0, 1'b1);
            dsp_slot(1'b0, 1'b0);
            for (int i = 0; i < 4; i++) dsp_frame(len_of(wl));
            compare("R5 pulse framing");
        end

        // R9: a right half-frame seen first after reset yields no pair
        do_reset(F_LJ, 2'b00);
        preamble(1'b1);
        std_half(F_LJ, 1'b0, mk(24), 24, 32);
        std_frame(F_LJ, 24, 32, mk(24), mk(24));
        preamble(1'b1);
        compare("R9 orphan right");
    endtask

    initial begin
        void'($urandom(32'd1955));
        fork
            begin
                run_all();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule